// File: doc/BRIEF.md
# Oversampled Serial Frame Encoder

This block turns a message of bytes into a framed serial stream on one bus line. A frame opens with a low transmission-start bit and a high frame-start bit. Each byte follows as a high-then-low byte-start pair and then its eight data bits. The frame closes with a low-then-high frame-end pair. Every logical bit is held on the line for eight consecutive clock cycles. The high-to-low edge inside each byte-start pair gives a receiver one falling edge per byte, which it can use to resynchronise its own sampling.

Bytes arrive on a valid/ready input that carries a last-byte flag. A frame begins when a start request and the first byte are both present. Each later byte is taken in the final clock cycle of the previous byte's last data bit, so bytes follow each other with no gap. If the source has no byte ready at that moment, and the previous byte was not flagged as last, the block raises an error flag and closes the frame.

Top module: `serial_frame_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_data` is 1, `tx_en` is 0, `err` is 0, and `in_ready` is 0 while `start` is low.
- R2: While idle, `in_ready` equals `start`. A handshake with `start`=1 and `in_valid`=1 begins a frame on the next cycle. The line is then 0 for 8 cycles (transmission start) and 1 for 8 cycles (frame start).
- R3: Each byte is preceded by a byte-start pair: 1 for 8 cycles, then 0 for 8 cycles.
- R4: Data bits follow the byte-start pair most significant bit first, bit 7 down to bit 0, each held for 8 cycles.
- R5: After the byte whose `in_last` was 1, the line is 0 for 8 cycles and then 1 for 8 cycles. The block then returns to idle.
- R6: During a frame, `in_ready` is 1 only in the final cycle of bit 0 of a byte that was not flagged last. A byte accepted there starts its byte-start pair on the next cycle.
- R7: If `in_valid` is 0 when a next byte is due, `err` is 1 for the 16 cycles of the frame-end pair that follows at once, and 0 at all other times.
- R8: A `start` request while `in_valid` is 0 is ignored: the block stays idle.
- R9: During a frame, `tx_data` changes only at the boundary of an 8-cycle bit period.
- R10: `tx_en` is 1 for exactly (4 + 10·n)·8 consecutive cycles for a frame of n bytes, starting with the transmission-start bit.
- R11: A synchronous reset during a frame returns the block to idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to open a frame; sampled while idle |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | Byte to transmit |
| in_last | input | 1 | The offered byte is the last of the message |
| in_ready | output | 1 | The offered byte is taken at this clock edge when `in_valid` is 1 |
| tx_data | output | 1 | Serial line value |
| tx_en | output | 1 | Transmitter enable; high for the whole frame |
| err | output | 1 | Underrun flag, high during an early frame-end pair |

## Verification
A wrong bit-period count shows up within one bit time. Every later symbol shifts, so the per-cycle comparison of `tx_data` and `tx_en` fails within eight cycles of the fault. A wrong symbol-sequence state, or a shifter that is loaded or stepped wrongly, puts a wrong level on the line in the very bit period concerned. A wrong last-byte or underrun decision shows at the next byte boundary: either `in_ready` opens at the wrong time, or the frame-end pair and `err` come early or late. Each of these is visible in at most ten bit periods.

// File: rtl/sfe_pkg.sv
// Shared types for the serial frame encoder.
// Assumes: one symbol is on the line at a time, and symbols follow the frame order.
package sfe_pkg;
    typedef enum logic [2:0] {
        SYM_IDLE,
        SYM_TXSTART,
        SYM_FRSTART,
        SYM_BYTEHI,
        SYM_BYTELO,
        SYM_DATA,
        SYM_ENDLO,
        SYM_ENDHI
    } sym_e;
endpackage

// File: rtl/sfe_bit_timer.sv
// Bit-period timer: counts the clock cycles within one logical bit.
// Assumes: run rises in the first cycle of a frame; the count is held at zero while idle.
module sfe_bit_timer #(
    parameter int CYC_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic period_end
);
    localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // Advance the cycle count, wrapping at the end of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign period_end = run && (cnt == LAST);

    // R9: a bit period never ends two cycles in a row (when it is longer than one cycle)
    p_period_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (CYC_PER_BIT > 1) && period_end |=> !period_end);
endmodule

// File: rtl/sfe_byte_shifter.sv
// Byte shifter: holds the byte being sent, presents its current bit MSB first,
// and keeps the byte's last-byte flag.
// Assumes: load and advance are never high in the same cycle.
module sfe_byte_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_last,
    input  logic              advance,
    output logic              cur_bit,
    output logic              final_bit,
    output logic              is_last
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] TOP = IW'(DATA_W - 1);

    logic [DATA_W-1:0] sreg;
    logic [IW-1:0]     idx;
    logic              last_q;

    // Load a new byte, or shift toward the next lower bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            idx    <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            sreg   <= load_data;
            idx    <= TOP;
            last_q <= load_last;
        end else if (advance) begin
            sreg   <= {sreg[DATA_W-2:0], 1'b0};
            idx    <= idx - IW'(1);
        end
    end

    assign cur_bit   = sreg[DATA_W-1];
    assign final_bit = (idx == '0);
    assign is_last   = last_q;

    // R4: the shifter is never stepped past its lowest bit
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !final_bit);
endmodule

// File: rtl/serial_frame_encoder.sv
// Serial frame encoder: sends a byte message as transmission start, frame start,
// then for each byte a high/low byte-start pair and its data bits MSB first,
// and finally a low/high frame-end pair. Every bit lasts CYC_PER_BIT cycles.
// Assumes: the source keeps in_valid high from start to the end of the message;
// a missing byte at a byte boundary is an underrun and ends the frame early.
module serial_frame_encoder
    import sfe_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CYC_PER_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tx_data,
    output logic              tx_en,
    output logic              err
);
    sym_e st, st_nx;
    logic bit_end, cur_bit, final_bit, is_last;
    logic byte_end, load, advance, underrun, err_q;

    sfe_bit_timer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st != SYM_IDLE),
        .period_end (bit_end)
    );

    sfe_byte_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (in_data),
        .load_last (in_last),
        .advance   (advance),
        .cur_bit   (cur_bit),
        .final_bit (final_bit),
        .is_last   (is_last)
    );

    // Decode the byte boundary and the handshake.
    always_comb begin
        byte_end = (st == SYM_DATA) && bit_end && final_bit;
        in_ready = ((st == SYM_IDLE) && start) || (byte_end && !is_last);
        load     = in_ready && in_valid;
        advance  = (st == SYM_DATA) && bit_end && !final_bit;
        underrun = byte_end && !is_last && !in_valid;
    end

    // Choose the next symbol of the frame.
    always_comb begin
        st_nx = st;
        if (st == SYM_IDLE) begin
            if (load) st_nx = SYM_TXSTART;
        end else if (bit_end) begin
            case (st)
                SYM_TXSTART: st_nx = SYM_FRSTART;
                SYM_FRSTART: st_nx = SYM_BYTEHI;
                SYM_BYTEHI:  st_nx = SYM_BYTELO;
                SYM_BYTELO:  st_nx = SYM_DATA;
                SYM_DATA:    st_nx = !final_bit ? SYM_DATA
                                   : (load ? SYM_BYTEHI : SYM_ENDLO);
                SYM_ENDLO:   st_nx = SYM_ENDHI;
                SYM_ENDHI:   st_nx = SYM_IDLE;
                default:     st_nx = SYM_IDLE;
            endcase
        end
    end

    // Register the symbol and the underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SYM_IDLE;
            err_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (underrun)
                err_q <= 1'b1;
            else if (st_nx == SYM_IDLE)
                err_q <= 1'b0;
        end
    end

    // Drive the line level that belongs to the current symbol.
    always_comb begin
        case (st)
            SYM_TXSTART, SYM_BYTELO, SYM_ENDLO: tx_data = 1'b0;
            SYM_DATA:                           tx_data = cur_bit;
            default:                            tx_data = 1'b1;
        endcase
    end

    assign tx_en = (st != SYM_IDLE);
    assign err   = err_q;

    // R1: the line rests high whenever the transmitter is off
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> tx_data);

    // R9: inside a frame the line level holds for the whole bit period
    p_bit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && $past(tx_en) && !$past(bit_end) |-> $stable(tx_data));

    // R6: during a frame, bytes are taken only at the end of a data bit
    p_ready_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && tx_en |-> bit_end && (st == SYM_DATA));

    // R7: the underrun flag is seen only during the frame-end pair
    p_err_in_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (st == SYM_ENDLO) || (st == SYM_ENDHI));

    // R3: the low half of a byte-start pair always follows its high half
    p_byte_start_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SYM_BYTELO) && ($past(st) != SYM_BYTELO) |-> $past(st) == SYM_BYTEHI);

    // R8: a start request with no byte leaves the block idle
    p_empty_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SYM_IDLE) && start && !in_valid |=> st == SYM_IDLE);
endmodule

// File: tb/serial_frame_encoder_test.sv
`timescale 1ns/1ps
module serial_frame_encoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready, tx_data, tx_en, err;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    serial_frame_encoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .tx_data(tx_data), .tx_en(tx_en), .err(err)
    );

    // Vector table: byte count, packed bytes (first byte in bits 31:24), last flag given
    localparam int NV = 5;
    localparam int          V_N   [NV] = '{1, 2, 3, 2, 4};
    localparam logic [31:0] V_B   [NV] = '{32'hA5000000, 32'h00FF0000, 32'h817EC300,
                                           32'h3C960000, 32'h12345678};
    localparam bit          V_LAST[NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int p, input int total, input logic [31:0] pk);
        int q;
        if (p == 0) return 1'b0;
        if (p == 1) return 1'b1;
        if (p == total - 2) return 1'b0;
        if (p == total - 1) return 1'b1;
        q = (p - 2) % 10;
        if (q == 0) return 1'b1;
        if (q == 1) return 1'b0;
        return pk[31 - 8 * ((p - 2) / 10) - (q - 2)];
    endfunction

    function automatic string phase_tag(input int p, input int total);
        if (p < 2) return "R2";
        if (p >= total) return "R1";
        if (p >= total - 2) return "R5";
        if ((p - 2) % 10 < 2) return "R3";
        return "R4";
    endfunction

    // Run one frame from a negedge; compare every output in every cycle.
    task automatic run_frame(input int nb, input logic [31:0] pk, input bit lastf);
        int  total = 4 + 10 * nb;
        int  idx = 0;
        bit  hs;
        logic exp_d, exp_en, exp_rdy, exp_err;
        start = 1'b1; in_valid = 1'b1; in_data = pk[31:24]; in_last = lastf && (nb == 1);
        #1;
        chk(in_ready === 1'b1, "R2", "in_ready with start while idle", in_ready, 1);
        hs = in_ready && in_valid;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < total * 8 + 8; c++) begin
            if (hs) idx++;
            in_valid = (idx < nb);
            in_data  = (idx < nb) ? pk[31 - 8 * idx -: 8] : 8'h00;
            in_last  = lastf && (idx == nb - 1);
            #1;
            exp_en  = (c < total * 8);
            exp_d   = exp_en ? exp_bit(c / 8, total, pk) : 1'b1;
            exp_rdy = 1'b0;
            for (int j = 0; j < nb; j++)
                if (c == 8 * (12 + 10 * j) - 1 && (j < nb - 1 || !lastf)) exp_rdy = 1'b1;
            exp_err = !lastf && (c >= (total - 2) * 8) && (c < total * 8);
            chk(tx_data === exp_d, phase_tag(c / 8, total), "tx_data", tx_data, exp_d);
            chk(tx_en === exp_en, "R10", "tx_en", tx_en, exp_en);
            chk(in_ready === exp_rdy, "R6", "in_ready", in_ready, exp_rdy);
            chk(err === exp_err, "R7", "err", err, exp_err);
            hs = in_valid && in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tx_data === 1'b1, "R1", "tx_data in reset", tx_data, 1);
        chk(tx_en === 1'b0, "R1", "tx_en in reset", tx_en, 0);
        chk(err === 1'b0, "R1", "err in reset", err, 0);
        chk(in_ready === 1'b0, "R1", "in_ready in reset", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_en === 1'b0 && tx_data === 1'b1, "R1", "idle after reset",
            {tx_en, tx_data}, 2'b01);

        for (int v = 0; v < NV; v++) begin
            run_frame(V_N[v], V_B[v], V_LAST[v]);
            @(negedge clk);
        end

        // R8: a start request with no byte is ignored
        start = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            chk(tx_en === 1'b0 && tx_data === 1'b1, "R8", "line after empty start",
                {tx_en, tx_data}, 2'b01);
            @(negedge clk);
        end

        // R11: reset in the middle of a frame
        start = 1'b1; in_valid = 1'b1; in_data = 8'hF0; in_last = 1'b1;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        chk(tx_en === 1'b1, "R2", "frame under way", tx_en, 1);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tx_en === 1'b0 && tx_data === 1'b1 && err === 1'b0, "R11",
            "idle after mid-frame reset", {tx_en, tx_data, err}, 3'b010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: back-to-back frames after recovery
        run_frame(1, 32'h5A000000, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule